// File: doc/BRIEF.md
# Integer ALU with Flag Update

This block is the integer execute unit of a 32-bit core. In one cycle it combines a register operand with a second operand and produces a result. The second operand is either a second register value or a 16-bit constant widened to full width. Eight operation codes cover four carry-chain operations, three bitwise operations and one special group. The special group holds bidirectional shifts and a conditional select. Shifts take their direction and distance from a single signed amount. Four condition flags (zero, negative, overflow, carry) live in a register inside the block. They are written on the clock edge only when the caller asks for it.

The datapath is purely combinational from operands to `result`. No data stream crosses the block's edge, so it has no valid/ready pair and no back-pressure. The caller presents an operation in a cycle, reads `result` in that same cycle, and sees the flags update after the next rising edge. The carry-in for add-with-carry and subtract-with-borrow is the stored carry flag.

Top module: `int_alu_flags`

## Requirements
- R1: Operation codes 000 add, 001 add with carry, 010 subtract and 011 subtract with borrow compute a + b + 0, a + b + C, a + ~b + 1 and a + ~b + C respectively. C is the stored carry flag.
- R2: Operation codes 100, 101 and 110 give the bitwise AND, OR and XOR of the two operands.
- R3: With `imm_mode`=1 and an operation code other than 111, `imm_hi`=1 places `imm` in bits 31:16 and `imm_hi`=0 places it in bits 15:0. The other half is 0x0000, or 0xFFFF for AND.
- R4: With `imm_mode`=1 and operation code 111, the operation is always a shift. `imm` is sign-extended to give the amount, and `imm_hi` selects logical (0) or arithmetic (1). A non-negative amount n from 0 to 31 shifts left by n. An amount of -1 to -31 shifts right by its magnitude.
- R5: With `imm_mode`=0 and operation code 111, `sub_fn` 10xxx is a logical shift and 11xxx is an arithmetic shift. The amount is `opnd_b` read as two's complement, with the same direction rule as R4.
- R6: With `imm_mode`=0, operation code 111 and `sub_fn`=00000, `result` is `opnd_a` when `cond_in`=1 and `opnd_b` otherwise. This select clears V and keeps C.
- R7: `flags_q` is {Z,N,V,C} in bits 3..0 and resets to 0000. It loads on the rising edge only when `flag_we`=1. With `flag_we`=0 it holds.
- R8: When flags are written, Z is 1 exactly when `result` is zero, and N equals `result` bit 31.
- R9: For the four carry-chain operations, V is 1 when the adder's two inputs agree in sign and the sum's sign differs. For subtract, the adder's second input is the inverted operand. Every other operation clears V.
- R10: For the four carry-chain operations, C is the carry out of bit 31 of the addition in R1.
- R11: A left shift sets C to the last bit shifted out, or 0 for a zero amount. A right shift clears C, and AND, OR and XOR clear C.
- R12: With `imm_mode`=0, operation code 111 and a `sub_fn` that is neither 1xxxx nor 00000, `illegal_op` is 1 and `result` is 0. The flags hold even when `flag_we`=1.
- R13: `illegal_op` is 0 for every operation that R12 does not name, including immediate-mode code 111 with any `sub_fn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| opcode | input | 3 | Operation code |
| imm_mode | input | 1 | 1 selects the expanded constant as second operand |
| imm_hi | input | 1 | Constant placement, or shift kind for immediate shifts |
| sub_fn | input | 5 | Special-group function in register mode |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Register second operand |
| imm | input | 16 | Constant for immediate mode |
| flag_we | input | 1 | Write the flag register on this edge |
| cond_in | input | 1 | Condition-true input for select |
| result | output | 32 | Operation result |
| flags_q | output | 4 | Stored flags {Z,N,V,C} |
| illegal_op | output | 1 | Reserved special function presented |

## Verification
The bench builds the block with its default width, 32 bits with a 16-bit constant. This keeps the extreme shift amounts +31 and -31, the 0xFFFF fill of an AND constant and sign-extension of a negative constant within a few directed items. Carry-chain cases at the 0x7FFFFFFF and 0xFFFFFFFF limits, and chained carry-in use, show the flag rules at their edges.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_ADDC = 3'b001,
    OP_SUB  = 3'b010,
    OP_SUBB = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_SPEC = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } alu_flags_t;

  localparam int SUBFN_W = 5;
endpackage

// File: rtl/alu_imm_expand.sv
module alu_imm_expand #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [HALF_W-1:0] imm,
  input  logic              place_hi,
  input  logic              fill_ones,
  input  logic              sign_ext,
  output logic [DATA_W-1:0] wide
);
  logic [HALF_W-1:0] fill;

  always_comb begin
    fill = fill_ones ? {HALF_W{1'b1}} : {HALF_W{1'b0}};
    if (sign_ext)
      wide = {{HALF_W{imm[HALF_W-1]}}, imm};
    else if (place_hi)
      wide = {imm, fill};
    else
      wide = {fill, imm};
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              invert_b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  logic [DATA_W-1:0] b_eff;

  always_comb begin
    b_eff = invert_b ? ~b : b;
    {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    ovf = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val,
  input  logic [DATA_W-1:0] amt,
  input  logic              arith,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic              go_right;
  logic [DATA_W-1:0] mag;
  logic [2*DATA_W-1:0] wide_l;

  always_comb begin
    go_right = amt[DATA_W-1];
    mag      = go_right ? (~amt + 1'b1) : amt;
    wide_l   = {{DATA_W{1'b0}}, val} << mag;
    if (go_right) begin
      res  = arith ? DATA_W'($signed(val) >>> mag) : (val >> mag);
      cout = 1'b0;
    end else begin
      res  = wide_l[DATA_W-1:0];
      cout = wide_l[DATA_W];
    end
  end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           opcode,
  input  logic                 imm_mode,
  input  logic                 imm_hi,
  input  logic [SUBFN_W-1:0]   sub_fn,
  input  logic [DATA_W-1:0]    opnd_a,
  input  logic [DATA_W-1:0]    opnd_b,
  input  logic [HALF_W-1:0]    imm,
  input  logic                 flag_we,
  input  logic                 cond_in,
  output logic [DATA_W-1:0]    result,
  output logic [3:0]           flags_q,
  output logic                 illegal_op
);
  alu_op_e     op;
  alu_flags_t  flg_r, flg_d;
  logic [DATA_W-1:0] imm_wide, b_sel;
  logic [DATA_W-1:0] as_sum, sh_res;
  logic as_cout, as_ovf, sh_cout;
  logic is_shift, is_select, is_reserved, sh_arith, carry_in;

  assign op = alu_op_e'(opcode);

  alu_imm_expand #(.DATA_W(DATA_W)) u_imm (
    .imm       (imm),
    .place_hi  (imm_hi),
    .fill_ones (op == OP_AND),
    .sign_ext  (op == OP_SPEC),
    .wide      (imm_wide)
  );

  assign b_sel    = imm_mode ? imm_wide : opnd_b;
  assign carry_in = opcode[0] ? flg_r.c : opcode[1];

  alu_addsub #(.DATA_W(DATA_W)) u_add (
    .a        (opnd_a),
    .b        (b_sel),
    .invert_b (opcode[1]),
    .cin      (carry_in),
    .sum      (as_sum),
    .cout     (as_cout),
    .ovf      (as_ovf)
  );

  assign sh_arith = imm_mode ? imm_hi : sub_fn[SUBFN_W-2];

  alu_shifter #(.DATA_W(DATA_W)) u_shf (
    .val   (opnd_a),
    .amt   (b_sel),
    .arith (sh_arith),
    .res   (sh_res),
    .cout  (sh_cout)
  );

  always_comb begin
    is_shift    = (op == OP_SPEC) && (imm_mode || sub_fn[SUBFN_W-1]);
    is_select   = (op == OP_SPEC) && !imm_mode && (sub_fn == '0);
    is_reserved = (op == OP_SPEC) && !is_shift && !is_select;
  end

  always_comb begin
    result  = '0;
    flg_d.v = 1'b0;
    flg_d.c = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
        result  = as_sum;
        flg_d.v = as_ovf;
        flg_d.c = as_cout;
      end
      OP_AND: result = opnd_a & b_sel;
      OP_OR:  result = opnd_a | b_sel;
      OP_XOR: result = opnd_a ^ b_sel;
      default: begin
        if (is_shift) begin
          result  = sh_res;
          flg_d.c = sh_cout;
        end else if (is_select) begin
          result  = cond_in ? opnd_a : b_sel;
          flg_d.c = flg_r.c;
        end
      end
    endcase
    flg_d.z = (result == '0);
    flg_d.n = result[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flg_r <= '0;
    else if (flag_we && !is_reserved)
      flg_r <= flg_d;
  end

  assign flags_q    = flg_r;
  assign illegal_op = is_reserved;
endmodule

// File: rtl/int_alu_flags_chk.sv
module int_alu_flags_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        opcode,
  input logic              imm_mode,
  input logic [4:0]        sub_fn,
  input logic              flag_we,
  input logic              cond_in,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags_q,
  input logic              illegal_op
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !flag_we) |=> $stable(flags_q)); // R7

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && illegal_op) |=> $stable(flags_q)); // R12

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (result == '0)); // R12

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && flag_we && !illegal_op) |=> (flags_q[3] == ($past(result) == '0))); // R8

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && flag_we && !illegal_op) |=> (flags_q[2] == $past(result[DATA_W-1]))); // R8

  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && flag_we && opcode[2] && (opcode != 3'b111)) |=> (flags_q[1:0] == 2'b00)); // R11

  AST_SELECT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_mode && opcode == 3'b111 && sub_fn == 5'b00000)
      |-> (result == (cond_in ? opnd_a : opnd_b))); // R6
endmodule

bind int_alu_flags int_alu_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opcode     (opcode),
  .imm_mode   (imm_mode),
  .sub_fn     (sub_fn),
  .flag_we    (flag_we),
  .cond_in    (cond_in),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .result     (result),
  .flags_q    (flags_q),
  .illegal_op (illegal_op)
);

// File: tb/sim_int_alu_flags.sv
module sim_int_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  opcode = '0;
  logic        imm_mode = 1'b0;
  logic        imm_hi = 1'b0;
  logic [4:0]  sub_fn = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [15:0] imm = '0;
  logic        flag_we = 1'b0;
  logic        cond_in = 1'b0;
  logic [31:0] result;
  logic [3:0]  flags_q;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  logic [3:0] mdl_flags = 4'b0000;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  flg;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  int_alu_flags u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .imm_mode(imm_mode),
    .imm_hi(imm_hi), .sub_fn(sub_fn), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm(imm), .flag_we(flag_we), .cond_in(cond_in), .result(result),
    .flags_q(flags_q), .illegal_op(illegal_op)
  );

  function automatic exp_t model(input logic [2:0] op, input logic im, input logic hi,
                                 input logic [4:0] sf, input logic [31:0] a,
                                 input logic [31:0] b, input logic [15:0] k,
                                 input logic we, input logic cnd, input logic [3:0] old);
    exp_t e;
    logic [31:0] bo, bb, r;
    logic [32:0] s;
    logic v, c, ill;
    int n;
    ill = 1'b0; v = 1'b0; c = 1'b0; r = '0;
    if (im) begin
      if (op == 3'b111) bo = {{16{k[15]}}, k};
      else if (hi)      bo = {k, (op == 3'b100) ? 16'hFFFF : 16'h0000};
      else              bo = {(op == 3'b100) ? 16'hFFFF : 16'h0000, k};
    end else bo = b;
    case (op)
      3'b000, 3'b001, 3'b010, 3'b011: begin
        bb = op[1] ? ~bo : bo;
        s = {1'b0, a} + {1'b0, bb} +
            ((op == 3'b000) ? 33'd0 : (op == 3'b010) ? 33'd1 : {32'd0, old[0]});
        r = s[31:0]; c = s[32];
        v = (a[31] == bb[31]) && (r[31] != a[31]);
      end
      3'b100: r = a & bo;
      3'b101: r = a | bo;
      3'b110: r = a ^ bo;
      default: begin
        if (im || sf[4]) begin
          n = $signed(bo);
          if (n >= 0) begin
            r = a << n;
            c = (n > 0) ? a[32-n] : 1'b0;
          end else begin
            r = (im ? hi : sf[3]) ? 32'($signed(a) >>> (-n)) : (a >> (-n));
          end
        end else if (sf == 5'b00000) begin
          r = cnd ? a : bo;
          c = old[0];
        end else ill = 1'b1;
      end
    endcase
    e.res = r;
    e.ill = ill;
    e.flg = (we && !ill) ? {r == 32'd0, r[31], v, c} : old;
    return e;
  endfunction

  task automatic apply(input string tag, input logic [2:0] op, input logic im,
                       input logic hi, input logic [4:0] sf, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] k,
                       input logic we, input logic cnd);
    exp_t e;
    opcode = op; imm_mode = im; imm_hi = hi; sub_fn = sf;
    opnd_a = a; opnd_b = b; imm = k; flag_we = we; cond_in = cnd;
    e = model(op, im, hi, sf, a, b, k, we, cnd, mdl_flags);
    e.tag = tag;
    mdl_flags = e.flg;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (sb.size() > 0);
      e = sb.pop_front();
      #2;
      checks++;
      if (result !== e.res || illegal_op !== e.ill) begin
        errors++;
        $display("FAIL %s result/illegal actual %h/%b expected %h/%b",
                 e.tag, result, illegal_op, e.res, e.ill);
      end
      @(posedge clk);
      #2;
      checks++;
      if (flags_q !== e.flg) begin
        errors++;
        $display("FAIL %s flags actual %b expected %b", e.tag, flags_q, e.flg);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (flags_q !== 4'b0000) begin
      errors++;
      $display("FAIL R7 reset flags actual %b expected 0000", flags_q);
    end
    // R1 R10 R8 R9 carry-chain cases
    apply("R1 add",           3'b000, 0, 0, 0, 32'd5, 32'd7, 0, 1, 0);
    apply("R10 add carry",    3'b000, 0, 0, 0, 32'hFFFFFFFF, 32'd1, 0, 1, 0);
    apply("R9 add overflow",  3'b000, 0, 0, 0, 32'h7FFFFFFF, 32'd1, 0, 1, 0);
    apply("R10 sub no borrow",3'b010, 0, 0, 0, 32'd5, 32'd3, 0, 1, 0);
    apply("R1 addc C=1",      3'b001, 0, 0, 0, 32'd1, 32'd1, 0, 1, 0);
    apply("R1 subb C=0",      3'b011, 0, 0, 0, 32'd10, 32'd3, 0, 1, 0);
    apply("R10 sub borrow",   3'b010, 0, 0, 0, 32'd3, 32'd5, 0, 1, 0);
    apply("R1 subb after borrow", 3'b011, 0, 0, 0, 32'd10, 32'd3, 0, 1, 0);
    apply("R9 sub overflow",  3'b010, 0, 0, 0, 32'h80000000, 32'd1, 0, 1, 0);
    // R2 R11 logic ops clear V and C
    apply("R2 and",           3'b100, 0, 0, 0, 32'hF0F0FFFF, 32'h0FF0F00F, 0, 1, 0);
    apply("R11 or",           3'b101, 0, 0, 0, 32'h80000000, 32'h00000001, 0, 1, 0);
    apply("R2 xor zero",      3'b110, 0, 0, 0, 32'h12345678, 32'h12345678, 0, 1, 0);
    // R3 immediate placement
    apply("R3 add imm low",   3'b000, 1, 0, 0, 32'h00010000, 32'hDEADBEEF, 16'h8001, 1, 0);
    apply("R3 add imm high",  3'b000, 1, 1, 0, 32'h00000003, 32'hDEADBEEF, 16'h8001, 1, 0);
    apply("R3 and imm low",   3'b100, 1, 0, 0, 32'h12345678, 32'h0, 16'h0F0F, 1, 0);
    apply("R3 and imm high",  3'b100, 1, 1, 0, 32'h12345678, 32'h0, 16'h0F0F, 1, 0);
    apply("R3 or imm high",   3'b101, 1, 1, 0, 32'h00000001, 32'h0, 16'hA000, 1, 0);
    // R4 R11 immediate shifts
    apply("R4 imm shl 4",     3'b111, 1, 0, 0, 32'hF0000001, 32'h0, 16'd4, 1, 0);
    apply("R11 imm shl 31",   3'b111, 1, 0, 0, 32'h00000003, 32'h0, 16'd31, 1, 0);
    apply("R4 imm lsr 4",     3'b111, 1, 0, 0, 32'h80000000, 32'h0, 16'hFFFC, 1, 0);
    apply("R4 imm asr 4",     3'b111, 1, 1, 0, 32'h80000000, 32'h0, 16'hFFFC, 1, 0);
    apply("R4 imm lsr 31",    3'b111, 1, 0, 0, 32'hFFFFFFFF, 32'h0, 16'hFFE1, 1, 0);
    apply("R11 imm shl 0",    3'b111, 1, 0, 0, 32'h80000001, 32'h0, 16'd0, 1, 0);
    apply("R13 imm spec sub", 3'b111, 1, 0, 5'b00001, 32'h1, 32'h0, 16'd1, 1, 0);
    // R5 register shifts
    apply("R5 reg lsl 8",     3'b111, 0, 0, 5'b10000, 32'h01234567, 32'd8, 0, 1, 0);
    apply("R5 reg asr 8",     3'b111, 0, 0, 5'b11000, 32'h87654321, 32'hFFFFFFF8, 0, 1, 0);
    apply("R5 reg lsr 8",     3'b111, 0, 0, 5'b10111, 32'h87654321, 32'hFFFFFFF8, 0, 1, 0);
    apply("R5 reg asr -31",   3'b111, 0, 0, 5'b11111, 32'h80000000, 32'hFFFFFFE1, 0, 1, 0);
    // R6 select, C kept
    apply("R10 set carry",    3'b000, 0, 0, 0, 32'hFFFFFFFF, 32'd2, 0, 1, 0);
    apply("R6 select true",   3'b111, 0, 0, 5'b00000, 32'hAAAA0000, 32'h00005555, 0, 1, 1);
    apply("R6 select false",  3'b111, 0, 0, 5'b00000, 32'hAAAA0000, 32'h00000000, 0, 1, 0);
    // R12 reserved, R7 write enable
    apply("R9 set V",         3'b000, 0, 0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 1, 0);
    apply("R12 reserved",     3'b111, 0, 0, 5'b00001, 32'h1, 32'h1, 0, 1, 0);
    apply("R12 reserved 01xxx", 3'b111, 0, 0, 5'b01000, 32'hFFFF, 32'h1, 0, 1, 0);
    apply("R7 no write",      3'b000, 0, 0, 0, 32'd0, 32'd0, 0, 0, 0);
    apply("R13 after hold",   3'b010, 0, 0, 0, 32'd0, 32'd0, 0, 1, 0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule